// File: doc/BRIEF.md
# Parallel Input Handshake Port

This block fetches bytes from an external input device over a two-wire handshake. It drives a request line (`reqOut`) to tell the device it is ready for a byte. It watches the device's acknowledge line (`ackIn`), which passes through a synchronizer before any edge detection. On a rising acknowledge it latches the eight port pins into a data register and sets a new-data flag. The CPU can poll that flag, or it can take an interrupt request when interrupts are enabled.

A mode bit selects the handshake style. In level (interlocked) mode the request stays high until the acknowledge arrives. The port then waits for the device to drop the acknowledge before it asks for the next byte. In pulse mode the request is a pulse of programmable width, and capture happens on the acknowledge edge. A CPU read of the data register clears the new-data flag and arms the next request. A control write with the start bit set also arms a request. If a byte arrives while the flag is still set, it overwrites the old byte and sets a sticky overrun bit.

Top module: `hsk_in_port`

## Requirements
- R1: After reset `reqOut` and `irqOut` are low, and the data (address 0), status (address 1) and control (address 2) registers all read 0.
- R2: In level mode an armed request raises `reqOut` and holds it high until a rising `ackIn` has been captured. A fall of `reqOut` follows a capture or happens in pulse mode.
- R3: A rising `ackIn` causes the port pins to be latched into the data register. The latch happens on the third rising clock edge after the input changes: two synchronizer stages, then the edge detector.
- R4: In level mode, once a byte is captured, `reqOut` stays low while `ackIn` is high, even if the port has been re-armed. A pending re-arm raises `reqOut` once the synchronized `ackIn` is low.
- R5: In pulse mode `reqOut` is high for exactly W clock cycles, where W is control bits 7:4. A value of 0 acts as 1. Capture still happens on a rising `ackIn`.
- R6: Status bit 0 (new data) is set on every capture. A read of the data register clears it.
- R7: `irqOut` is high exactly when control bit 0 (interrupt enable) and the new-data flag are both set.
- R8: A capture while new data is still set overwrites the byte and sets status bit 1 (overrun). The overrun bit stays set until a read of the status register.
- R9: A data-register read, or a control write with bit 2 (start) set, arms a request. This happens only when no transfer is in progress. An arm during an active request or pulse is ignored. Control bit 1 selects pulse mode, and bit 2 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address: 0 data, 1 status, 2 control |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the address |
| portPins | input | 8 | Input data pins from the device |
| ackIn | input | 1 | Device acknowledge (asynchronous) |
| reqOut | output | 1 | Request to the device |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- each capture loads the sampled pin value and sets the new-data flag;
- a capture on top of unread data raises overrun;
- every rise of the interrupt line traces back to a capture or a control write;
- a drop of the request in level mode is always caused by a capture.

Some behaviour depends on multi-cycle sequences, and only the bench scenarios show it:
- the exact pulse width, including the zero-means-one case;
- holding off the next level-mode request until the acknowledge is released;
- ignoring an arm during a pulse;
- the three-edge capture latency.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int CNT_W  = 4;

  localparam logic [ADDR_W-1:0] ADDR_DATA   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_PULSE, ST_WAITACK, ST_RELEASE
  } hskState_t;

  typedef struct packed {
    logic capture;
    logic dataRead;
    logic statRead;
    logic ctrlWrite;
  } hskStrobe_t;
endpackage

// File: rtl/hsk_ctrl.sv
module hsk_ctrl
  import hsk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrStart,
  input  logic              wrMode,
  input  logic [CW-1:0]     wrWidth,
  input  logic              pulseMode,
  input  logic [CW-1:0]     pulseWidth,
  input  logic              ackIn,
  output logic              reqOut,
  output hskStrobe_t        strb
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic ackSync, ackPrev, ackRise;
  hskState_t state;
  logic [CW-1:0] cnt;
  logic armPend;
  logic arm, effMode;
  logic [CW-1:0] effWidth, cntInit;

  // synchronizer chain
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= ackIn;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], ackIn};
    end
  endgenerate

  assign ackSync = syncQ[SYNC_STAGES-1];
  assign ackRise = ackSync & ~ackPrev;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) ackPrev <= 1'b0;
    else       ackPrev <= ackSync;

  // bus decode
  always_comb begin
    strb.capture   = ackRise;
    strb.dataRead  = busSel & ~busWr & (busAddr == ADDR_DATA);
    strb.statRead  = busSel & ~busWr & (busAddr == ADDR_STATUS);
    strb.ctrlWrite = busSel &  busWr & (busAddr == ADDR_CTRL);
  end

  assign arm      = strb.dataRead | (strb.ctrlWrite & wrStart);
  assign effMode  = strb.ctrlWrite ? wrMode  : pulseMode;
  assign effWidth = strb.ctrlWrite ? wrWidth : pulseWidth;
  assign cntInit  = (effWidth == '0) ? CW'(1) : effWidth;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      armPend <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ackRise) begin
            state   <= pulseMode ? ST_IDLE : ST_RELEASE;
            armPend <= arm;
          end else if (arm) begin
            state <= effMode ? ST_PULSE : ST_REQ;
            cnt   <= cntInit;
          end
        end
        ST_REQ, ST_WAITACK: begin
          if (ackRise) begin
            state   <= pulseMode ? ST_IDLE : ST_RELEASE;
            armPend <= 1'b0;
          end
        end
        ST_PULSE: begin
          if (ackRise) begin
            state   <= pulseMode ? ST_IDLE : ST_RELEASE;
            armPend <= 1'b0;
          end else if (cnt <= CW'(1)) begin
            state <= ST_WAITACK;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_RELEASE: begin
          if (!ackSync) begin
            armPend <= 1'b0;
            if (armPend || arm) begin
              state <= effMode ? ST_PULSE : ST_REQ;
              cnt   <= cntInit;
            end else begin
              state <= ST_IDLE;
            end
          end else if (arm) begin
            armPend <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqOut = (state == ST_REQ) || (state == ST_PULSE);
endmodule

// File: rtl/hsk_datapath.sv
module hsk_datapath
  import hsk_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  hskStrobe_t        strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrIntEn,
  input  logic              wrMode,
  input  logic [CW-1:0]     wrWidth,
  input  logic [DW-1:0]     portPins,
  output logic [DW-1:0]     busRdata,
  output logic [DW-1:0]     dataQ,
  output logic              newData,
  output logic              overrun,
  output logic              intEn,
  output logic              pulseMode,
  output logic [CW-1:0]     pulseWidth,
  output logic              irqOut
);
  localparam int PAD_W = DW - CW - 2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ      <= '0;
      newData    <= 1'b0;
      overrun    <= 1'b0;
      intEn      <= 1'b0;
      pulseMode  <= 1'b0;
      pulseWidth <= '0;
    end else begin
      if (strb.capture) begin
        dataQ   <= portPins;
        newData <= 1'b1;
      end else if (strb.dataRead) begin
        newData <= 1'b0;
      end
      if (strb.capture && newData) overrun <= 1'b1;
      else if (strb.statRead)      overrun <= 1'b0;
      if (strb.ctrlWrite) begin
        intEn      <= wrIntEn;
        pulseMode  <= wrMode;
        pulseWidth <= wrWidth;
      end
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_DATA:   busRdata = dataQ;
      ADDR_STATUS: busRdata = {{(DW-2){1'b0}}, overrun, newData};
      ADDR_CTRL:   busRdata = {pulseWidth, {PAD_W{1'b0}}, pulseMode, intEn};
      default:     busRdata = '0;
    endcase
  end

  assign irqOut = intEn & newData;
endmodule

// File: rtl/hsk_in_port.sv
module hsk_in_port
  import hsk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] portPins,
  input  logic              ackIn,
  output logic              reqOut,
  output logic              irqOut
);
  hskStrobe_t strb;
  logic pulseMode, newData, overrun, intEn;
  logic [CNT_W-1:0] pulseWidth;
  logic [DATA_W-1:0] dataQ;

  hsk_ctrl #(.SYNC_STAGES(2), .CW(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .wrStart(busWdata[2]), .wrMode(busWdata[1]),
    .wrWidth(busWdata[DATA_W-1 -: CNT_W]),
    .pulseMode(pulseMode), .pulseWidth(pulseWidth), .ackIn(ackIn),
    .reqOut(reqOut), .strb(strb)
  );

  hsk_datapath #(.DW(DATA_W), .CW(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .wrIntEn(busWdata[0]), .wrMode(busWdata[1]),
    .wrWidth(busWdata[DATA_W-1 -: CNT_W]),
    .portPins(portPins), .busRdata(busRdata), .dataQ(dataQ),
    .newData(newData), .overrun(overrun), .intEn(intEn),
    .pulseMode(pulseMode), .pulseWidth(pulseWidth), .irqOut(irqOut)
  );
endmodule

// File: rtl/hsk_in_port_chk.sv
module hsk_in_port_chk
  import hsk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              capture,
  input logic              ctrlWrite,
  input logic [DATA_W-1:0] portPins,
  input logic [DATA_W-1:0] dataQ,
  input logic              newData,
  input logic              overrun,
  input logic              pulseMode,
  input logic              reqOut,
  input logic              irqOut
);
  assert_capture_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> dataQ == $past(portPins));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> newData);

  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    capture && newData |=> overrun);

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(capture || ctrlWrite));

  assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqOut) |-> $past(capture) || $past(pulseMode));
endmodule

bind hsk_in_port hsk_in_port_chk chk (
  .clk(clk), .rstN(rstN), .capture(strb.capture), .ctrlWrite(strb.ctrlWrite),
  .portPins(portPins), .dataQ(dataQ), .newData(newData), .overrun(overrun),
  .pulseMode(pulseMode), .reqOut(reqOut), .irqOut(irqOut)
);

// File: tb/hsk_in_port_test.sv
module hsk_in_port_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata;
  logic [7:0] portPins = '0;
  logic ackIn = 1'b0;
  logic reqOut, irqOut;
  int checks = 0, fails = 0;
  int reqHighCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsk_in_port uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .portPins(portPins),
    .ackIn(ackIn), .reqOut(reqOut), .irqOut(irqOut)
  );

  always @(negedge clk) if (reqOut) reqHighCnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; ackIn = 1'b0; portPins = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic devAck(input logic [7:0] v);
    @(negedge clk);
    portPins = v; ackIn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic devRelease();
    @(negedge clk);
    ackIn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    doReset();
    check("R1 reqOut", reqOut, 0);
    check("R1 irqOut", irqOut, 0);
    busRead(2'd0, d); check("R1 data", d, 0);
    busRead(2'd1, d); check("R1 status", d, 0);
    busRead(2'd2, d); check("R1 control", d, 0);
  endtask

  task automatic testLevel();
    logic [7:0] d;
    doReset();
    busWrite(2'd2, 8'h04);
    check("R2 req raised", reqOut, 1);
    repeat (5) @(negedge clk);
    check("R2 req held", reqOut, 1);
    devAck(8'hA5);
    check("R2 req dropped after capture", reqOut, 0);
    busRead(2'd1, d); check("R6 new data set", d, 1);
    busRead(2'd0, d); check("R3 captured byte", d, 8'hA5);
    repeat (4) @(negedge clk);
    check("R4 no request while ack high", reqOut, 0);
    busRead(2'd1, d); check("R6 cleared by data read", d, 0);
    devRelease();
    check("R4 pending re-arm after release", reqOut, 1);
    devAck(8'h3C);
    devRelease();
    busRead(2'd0, d); check("R3 second byte", d, 8'h3C);
  endtask

  task automatic testPulse();
    logic [7:0] d;
    int base;
    doReset();
    base = reqHighCnt;
    busWrite(2'd2, 8'h36);
    repeat (8) @(negedge clk);
    check("R5 pulse width 3", reqHighCnt - base, 3);
    busRead(2'd2, d); check("R9 control readback", d, 8'h32);
    devAck(8'h5A);
    check("R5 req low after ack", reqOut, 0);
    devRelease();
    busRead(2'd0, d); check("R5 pulse capture", d, 8'h5A);
    doReset();
    base = reqHighCnt;
    busWrite(2'd2, 8'h06);
    repeat (6) @(negedge clk);
    check("R5 width zero acts as one", reqHighCnt - base, 1);
    doReset();
    base = reqHighCnt;
    busWrite(2'd2, 8'h36);
    busWrite(2'd2, 8'h36);
    repeat (8) @(negedge clk);
    check("R9 arm during pulse ignored", reqHighCnt - base, 3);
  endtask

  task automatic testOverrun();
    logic [7:0] d;
    doReset();
    busWrite(2'd2, 8'h04);
    devAck(8'h11);
    devRelease();
    busWrite(2'd2, 8'h04);
    check("R9 start bit arms", reqOut, 1);
    devAck(8'h22);
    devRelease();
    busRead(2'd1, d); check("R8 overrun and new data", d, 8'h03);
    busRead(2'd1, d); check("R8 overrun cleared by status read", d, 8'h01);
    busRead(2'd0, d); check("R8 byte overwritten", d, 8'h22);
    busRead(2'd1, d); check("R6 status clear", d, 8'h00);
  endtask

  task automatic testIrq();
    logic [7:0] d;
    doReset();
    busWrite(2'd2, 8'h05);
    check("R7 irq low before data", irqOut, 0);
    devAck(8'h77);
    check("R7 irq on new data", irqOut, 1);
    busWrite(2'd2, 8'h00);
    check("R7 irq masked", irqOut, 0);
    busRead(2'd1, d); check("R7 flag kept while masked", d, 1);
    busWrite(2'd2, 8'h01);
    check("R7 irq unmasked", irqOut, 1);
    devRelease();
    busRead(2'd0, d); check("R7 data", d, 8'h77);
    check("R7 irq cleared by data read", irqOut, 0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testLevel();
    testPulse();
    testOverrun();
    testIrq();
    finishRun();
  end
endmodule